// File: doc/BRIEF.md
# Bidirectional Dual-Port Shift Register

This block is an eight-stage storage register with two parallel data ports, called A and B, and a one-bit serial input. Four control inputs select its mode and the direction of the ports. `a_en` enables port A. `par_mode` picks between parallel and serial operation. `dir_ab` sets which way data moves between the ports. `async_ld` picks between a clocked load and a level-transparent load. In serial mode the register shifts toward its high end on every rising clock edge. In parallel mode it takes a word from one port and presents its contents on the other.

Each port has an output data bus and an active-high output enable. Both output buses always carry the visible contents. The enable says whether that port should drive its pad. The pad buffers are left to the level above this block. A transparent load lets the selected input port pass through to the outputs in the same cycle. The flip-flops capture the same word on every edge while the transparent load is active, so the word is held once `async_ld` falls. Keep `async_ld` low while switching from parallel back to serial mode.

Top module: `dual_port_shift_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all stages clear to 0, and both output buses then read 0x00.
- R2: With `par_mode` = 0, each rising edge moves stage i into stage i+1 and loads `ser_in` into stage 0 (bit 0). `async_ld` and both input buses have no effect in this mode.
- R3: With `par_mode` = 0 and `dir_ab` = 0, `b_oe` is 0 and `a_oe` equals `a_en`. With `par_mode` = 0 and `dir_ab` = 1, `b_oe` is 1 and `a_oe` is 0.
- R4: With `par_mode` = 1 and `dir_ab` = 0, the register loads `b_in`, `b_oe` is 0, and `a_oe` equals `a_en`.
- R5: With `par_mode` = 1, `dir_ab` = 1 and `a_en` = 1, the register loads `a_in`, `b_oe` is 1, and `a_oe` is 0.
- R6: With `par_mode` = 1, `dir_ab` = 1 and `a_en` = 0, no load takes place and the contents hold whatever `a_in` and `async_ld` are. `b_oe` stays 1 and `a_oe` stays 0.
- R7: During a parallel load with `async_ld` = 1, both output buses show the source port in the same cycle, before any clock edge. The value is still held after `async_ld` returns to 0.
- R8: During a parallel load with `async_ld` = 0, the outputs keep the old contents until the next rising edge and show the new word only after it.
- R9: `a_oe` and `b_oe` are never both 1, and `a_out` always equals `b_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register acts on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en | input | 1 | Port A enable |
| par_mode | input | 1 | 1 selects parallel operation, 0 selects serial operation |
| dir_ab | input | 1 | 0 loads from B and presents on A; 1 loads from A and presents on B |
| async_ld | input | 1 | 1 makes a parallel load transparent, 0 makes it clocked |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | WIDTH | Port A input word |
| b_in | input | WIDTH | Port B input word |
| a_out | output | WIDTH | Port A output word (the visible contents) |
| a_oe | output | 1 | Port A drive enable |
| b_out | output | WIDTH | Port B output word (the visible contents) |
| b_oe | output | 1 | Port B drive enable |

## Verification
The bench walks a vector table that applies all twelve distinct control combinations: the four serial ones, with `async_ld` toggled to show it has no effect, and all eight parallel ones. The same table checks both enables, which separates the port-A gating by `a_en` from the port-B direction, and checks the source port, which separates a load from A, a load from B and a blocked load. Directed tests sample inside a cycle, so a transparent load is told apart from a clocked one. A full eight-edge shift of a pattern checks the stage ordering, and a reset is applied after the register holds 0xFF.

// File: rtl/dpsr_pkg.sv
// Package: shared control type for the dual-port shift register.
// Assumes: the decoder fills every field each cycle from the control pins.
package dpsr_pkg;

    // Decoded per-cycle control for the storage and port logic.
    typedef struct packed {
        logic shift;        // serial shift on this edge
        logic load;         // parallel load from the selected port is active
        logic src_a;        // 1: source is port A, 0: source is port B
        logic transparent;  // outputs follow the source without a clock
        logic a_oe;         // port A drives
        logic b_oe;         // port B drives
    } dpsr_ctl_t;

endpackage

// File: rtl/dpsr_mode_decode.sv
// Module: dpsr_mode_decode
// Turns the four control pins into the shift, load, source-select,
// transparency and output-enable terms. Purely combinational.
// Assumes: all control inputs are synchronous to the clock domain of the register.
module dpsr_mode_decode
    import dpsr_pkg::*;
(
    input  logic       a_en,
    input  logic       par_mode,
    input  logic       dir_ab,
    input  logic       async_ld,
    output dpsr_ctl_t  ctl
);

    logic load_ok;

    // A load is blocked only when port A is the source and port A is disabled.
    assign load_ok = par_mode && (!dir_ab || a_en);

    // Build the decoded control word.
    always_comb begin
        ctl             = '0;
        ctl.shift       = !par_mode;
        ctl.load        = load_ok;
        ctl.src_a       = dir_ab;
        ctl.transparent = load_ok && async_ld;
        ctl.a_oe        = a_en && !dir_ab;
        ctl.b_oe        = dir_ab;
    end

endmodule

// File: rtl/dpsr_stage_reg.sv
// Module: dpsr_stage_reg
// The WIDTH flip-flop stages. Each stage picks its next value from the
// lower neighbour (shift), the load word (load) or itself (hold).
// Assumes: shift and load are never both set (guaranteed by the decoder).
module dpsr_stage_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             load,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] d;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Stage 0 takes the serial input on a shift.
                always_comb d[gi] = shift ? ser_in : (load ? load_word[gi] : q[gi]);
            end else begin : g_rest
                // Higher stages take the stage below on a shift.
                always_comb d[gi] = shift ? q[gi-1] : (load ? load_word[gi] : q[gi]);
            end
        end
    endgenerate

    // Stage update with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dpsr_port_mux.sv
// Module: dpsr_port_mux
// Selects the load source port and forms the visible contents. During a
// transparent load the source passes straight to the outputs.
// Assumes: src_a and transparent come from the mode decoder.
module dpsr_port_mux #(
    parameter int WIDTH = 8
) (
    input  logic             src_a,
    input  logic             transparent,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] view
);

    // Pick the source port for a load.
    always_comb load_word = src_a ? a_in : b_in;

    // Visible contents: the source while transparent, otherwise the stages.
    always_comb view = transparent ? load_word : q;

endmodule

// File: rtl/dual_port_shift_reg.sv
// Module: dual_port_shift_reg (top)
// A WIDTH-stage shift register with two parallel ports whose direction,
// enable and load timing are set by four control pins. The output buses
// always carry the visible contents; a_oe/b_oe say which pad may drive.
// Assumes: the pad buffers are built above this block; async_ld is held
// low when leaving parallel mode.
module dual_port_shift_reg
    import dpsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic             par_mode,
    input  logic             dir_ab,
    input  logic             async_ld,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    dpsr_ctl_t        ctl;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] load_word;
    logic [WIDTH-1:0] view;

    dpsr_mode_decode u_dec (
        .a_en     (a_en),
        .par_mode (par_mode),
        .dir_ab   (dir_ab),
        .async_ld (async_ld),
        .ctl      (ctl)
    );

    dpsr_port_mux #(.WIDTH(WIDTH)) u_mux (
        .src_a       (ctl.src_a),
        .transparent (ctl.transparent),
        .a_in        (a_in),
        .b_in        (b_in),
        .q           (q),
        .load_word   (load_word),
        .view        (view)
    );

    dpsr_stage_reg #(.WIDTH(WIDTH)) u_stages (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (ctl.shift),
        .load      (ctl.load),
        .ser_in    (ser_in),
        .load_word (load_word),
        .q         (q)
    );

    // Drive both port buses and enables.
    always_comb begin
        a_out = view;
        b_out = view;
        a_oe  = ctl.a_oe;
        b_oe  = ctl.b_oe;
    end

endmodule

// File: rtl/dpsr_checker.sv
// Module: dpsr_checker
// Assertions on the ports of dual_port_shift_reg, attached by bind.
module dpsr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_en,
    input logic             par_mode,
    input logic             dir_ab,
    input logic             async_ld,
    input logic             ser_in,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe
);

    logic now_transp;
    assign now_transp = par_mode && async_ld;

    // R2: a serial edge shifts the old contents up and brings ser_in into bit 0.
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!par_mode) && !now_transp)
        |-> b_out == {$past(b_out[WIDTH-2:0]), $past(ser_in)});

    // R4: a clocked load from port B.
    p_load_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(par_mode && !dir_ab) && !now_transp)
        |-> b_out == $past(b_in));

    // R5: a clocked load from port A.
    p_load_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(par_mode && dir_ab && a_en) && !now_transp)
        |-> a_out == $past(a_in));

    // R6: a blocked load holds the contents.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(par_mode && dir_ab && !a_en) && !now_transp)
        |-> $stable(b_out));

    // R7: a transparent load from B shows on the outputs at once.
    p_transp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && async_ld && !dir_ab) |-> a_out == b_in);

    // R9: the two port enables never drive together.
    p_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    // R3: port B drives in serial mode exactly when dir_ab is 1.
    p_ser_boe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode) |-> (b_oe == dir_ab));

endmodule

bind dual_port_shift_reg dpsr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_port_shift_reg_tb.sv
module dual_port_shift_reg_tb;

    localparam int W     = 8;
    localparam int NVEC  = 14;
    localparam int LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         a_en = 1'b0, par_mode = 1'b0, dir_ab = 1'b0, async_ld = 1'b0, ser_in = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_port_shift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_en(a_en), .par_mode(par_mode), .dir_ab(dir_ab),
        .async_ld(async_ld), .ser_in(ser_in), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // Vector layout: [28:24] {a_en,par_mode,dir_ab,async_ld,ser_in},
    // [23:16] a_in, [15:8] b_in, [7:0] contents expected after the edge.
    localparam logic [31:0] VEC [NVEC] = '{
        32'h11_00_00_01, 32'h02_00_00_02, 32'h05_00_00_05, 32'h15_00_00_0B,
        32'h18_00_A5_A5, 32'h08_00_3C_3C, 32'h1C_C3_00_C3, 32'h0C_FF_00_C3,
        32'h0E_00_00_C3, 32'h1A_00_5A_5A, 32'h1E_96_00_96, 32'h0A_00_81_81,
        32'h10_00_00_02, 32'h05_00_00_05
    };

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_ctl(input logic [4:0] c);
        {a_en, par_mode, dir_ab, async_ld, ser_in} = c;
    endtask

    initial begin
        // R1: synchronous reset clears the stages.
        repeat (3) @(posedge clk);
        #1 chk("R1 reset value", a_out, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        // Table walk over all twelve control combinations.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            set_ctl(VEC[i][28:24]);
            a_in = VEC[i][23:16];
            b_in = VEC[i][15:8];
            #1;
            // R3/R4/R5/R6: enables from a_en and dir_ab.
            chk("R3-oe a", {7'd0, a_oe}, {7'd0, a_en && !dir_ab});
            chk("R3-oe b", {7'd0, b_oe}, {7'd0, dir_ab});
            @(posedge clk);
            #1;
            // R2 serial, R4 load B, R5 load A, R6 hold, R7 transparent.
            chk("R2/R4/R5/R6/R7 contents", b_out, VEC[i][7:0]);
            chk("R9 buses equal", a_out, b_out);
        end

        // R7: transparent load seen inside the cycle, held after select drops.
        @(negedge clk);
        set_ctl(5'b11010); b_in = 8'hE7;
        #0.5 chk("R7 transparent same cycle", a_out, 8'hE7);
        @(posedge clk);
        @(negedge clk);
        set_ctl(5'b01100); a_in = 8'h00;
        #1 chk("R7 held after drop", b_out, 8'hE7);

        // R8: clocked load stays invisible until the edge.
        @(negedge clk);
        set_ctl(5'b11000); b_in = 8'h11;
        #1 chk("R8 before edge", a_out, 8'hE7);
        @(posedge clk);
        #1 chk("R8 after edge", a_out, 8'h11);

        // R2: full eight-stage shift of a pattern; async_ld set and ignored.
        for (int k = W - 1; k >= 0; k--) begin
            @(negedge clk);
            set_ctl({4'b0001, 1'b0});
            ser_in = logic'((8'hB4 >> k) & 8'h01);
            a_in = 8'hFF; b_in = 8'hFF;
        end
        @(posedge clk);
        #1 chk("R2 full shift", b_out, 8'hB4);

        // R1: reset from a full register.
        @(negedge clk);
        set_ctl(5'b11000); b_in = 8'hFF;
        @(posedge clk);
        #1 chk("R1 preload", b_out, 8'hFF);
        @(negedge clk) rst_n = 1'b0;
        set_ctl(5'b00000);
        @(posedge clk);
        #1 chk("R1 reset clears", b_out, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule